// File: doc/BRIEF.md
# Registered 8-bit ALU with log-depth barrel shifter

This block is the execution unit of a small 8-bit core. In a single cycle it performs arithmetic, bitwise logic, logical shifts and rotates on two operands, and it produces the next values of the zero and carry flags. It also asserts a write strobe that tells the register file whether to store the result. The second operand carries the shift or rotate amount. The decoder drives that port from either a register value or an immediate field, so the two sources behave the same.

The shift path is a log-depth network of stages. Each stage moves the word by a power of two, and the same stages serve left and right shifts and both rotate directions. Every next value is computed combinationally from the inputs and the current flag state, and it is captured at the rising clock edge. The outputs therefore show the result of the operands presented in the previous cycle. A flag-only test operation updates the zero flag, leaves carry as it was and deasserts the write strobe. The core can use this state for conditional branches.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) gives res = (a + b) mod 256, and carry equals the carry out of bit 7.
- R2: Operation code 1 (subtract) gives res = (a - b) mod 256, with carry = 1 exactly when a >= b unsigned. Subtracting n gives the same result as adding (256 - n) mod 256.
- R3: Operation codes 2, 3 and 4 give a AND b, a OR b and a XOR b, and each of them clears carry.
- R4: Operation code 5 shifts a left and code 6 shifts a right by b[2:0] places. Vacated positions are filled with zeros, bits b[7:3] are ignored, and carry is cleared.
- R5: Operation code 7 rotates a left and code 8 rotates a right by b[2:0] places. Bits leave one end and re-enter at the other, and carry is cleared.
- R6: A shift amount of 0 passes a through unchanged for all four shift and rotate codes.
- R7: For codes 0 to 8, zero is 1 exactly when the 8-bit result is 0x00.
- R8: Operation code 9 (test) sets zero to 1 exactly when (a AND b) is 0x00, keeps carry at its previous value, deasserts wr, and shows a AND b on res.
- R9: wr is 1 after codes 0 to 8. Codes 10 to 15 deassert wr and keep res, zero and carry unchanged.
- R10: Outputs change only at the rising clock edge that samples the inputs. While rst_n is low, res, zero, carry and wr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand or shift amount |
| res_o | output | 8 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry flag |
| wr_o | output | 1 | Result write strobe |

## Verification
Carry generation and zero detection can both become true in the same cycle. This happens when an add wraps to exactly 0x00 (0x80 + 0x80, 0x01 + 0xFF), or when a subtract of equal operands has no borrow and a zero difference. The bench steers operands into these cases on purpose, and checks that both flags are set together against a bench model that computes each flag separately. A second coincidence comes from a test operation that follows a carry-setting add: the zero flag must move while carry must not. The bench judges this with a bench-side carry history rather than by reading the design back.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8,
        OP_TST = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } lg_e;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    // Subtract as a + ~b + 1: carry out set means no borrow.
    logic [WIDTH:0] total;
    logic [WIDTH-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    assign sum   = total[WIDTH-1:0];
    assign cout  = total[WIDTH];
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  lg_e              sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (sel)
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/alu_barrel.sv
`timescale 1ns/1ps
module alu_barrel #(
    parameter int WIDTH = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] x,
    input  logic [SH_W-1:0]  amt,
    input  logic             left,
    input  logic             rot,
    output logic [WIDTH-1:0] y
);
    // One stage per amount bit; stage k moves by 2**k. WIDTH is a power of two.
    logic [WIDTH-1:0] stg [SH_W+1];

    assign stg[0] = x;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [WIDTH-1:0] moved;

        always_comb begin
            if (left) begin
                moved = (stg[k] << STEP) | (rot ? (stg[k] >> (WIDTH - STEP)) : '0);
            end else begin
                moved = (stg[k] >> STEP) | (rot ? (stg[k] << (WIDTH - STEP)) : '0);
            end
        end

        assign stg[k+1] = amt[k] ? moved : stg[k];
    end

    assign y = stg[SH_W];
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             wr_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zero;
        logic             carry;
        logic             wr;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [WIDTH-1:0] as_sum, lg_y, sh_y;
    logic             as_cout;
    logic             as_sub, sh_left, sh_rot;
    lg_e              lg_sel;

    assign op      = op_e'(op_i);
    assign as_sub  = (op == OP_SUB);
    assign sh_left = (op == OP_SHL) || (op == OP_ROL);
    assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

    always_comb begin
        case (op)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .a    (a_i),
        .b    (b_i),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu_logic #(.WIDTH(WIDTH)) i_logic (
        .a   (a_i),
        .b   (b_i),
        .sel (lg_sel),
        .y   (lg_y)
    );

    alu_barrel #(.WIDTH(WIDTH)) i_barrel (
        .x    (a_i),
        .amt  (b_i[SH_W-1:0]),
        .left (sh_left),
        .rot  (sh_rot),
        .y    (sh_y)
    );

    // Next-state computation.
    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                st_d.res   = as_sum;
                st_d.carry = as_cout;
                st_d.wr    = 1'b1;
                st_d.zero  = (as_sum == '0);
            end
            OP_AND, OP_OR, OP_XOR: begin
                st_d.res   = lg_y;
                st_d.carry = 1'b0;
                st_d.wr    = 1'b1;
                st_d.zero  = (lg_y == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                st_d.res   = sh_y;
                st_d.carry = 1'b0;
                st_d.wr    = 1'b1;
                st_d.zero  = (sh_y == '0);
            end
            OP_TST: begin
                st_d.res  = lg_y;
                st_d.zero = (lg_y == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = st_q.res;
    assign zero_o  = st_q.zero;
    assign carry_o = st_q.carry;
    assign wr_o    = st_q.wr;

    // Subtract carry means no borrow.
    a_r2_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB) |=> (carry_o == ($past(a_i) >= $past(b_i))));

    // Logic, shift and rotate codes clear carry.
    a_r3_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i >= OP_AND) && (op_i <= OP_ROR)) |=> !carry_o);

    // Left shift fills the low positions with zeros.
    a_r4_shl_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHL) |=>
        ((res_o & ((WIDTH'(1) << $past(b_i[SH_W-1:0])) - WIDTH'(1))) == '0));

    // A rotate keeps the number of set bits.
    a_r5_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_ROL) || (op_i == OP_ROR)) |=>
        ($countones(res_o) == $countones($past(a_i))));

    // A zero amount passes the operand through.
    a_r6_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i >= OP_SHL) && (op_i <= OP_ROR) && (b_i[SH_W-1:0] == '0)) |=>
        (res_o == $past(a_i)));

    // Test mode: no write, and carry is kept.
    a_r8_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_TST) |=> (!wr_o && $stable(carry_o)));

    // Unused codes: no write, and result and flags are kept.
    a_r9_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_TST) |=> (!wr_o && $stable(res_o) && $stable(zero_o) && $stable(carry_o)));
endmodule

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] a_i = 8'd0;
    logic [7:0] b_i = 8'd0;
    logic [7:0] res_o;
    logic       zero_o, carry_o, wr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] e_res   = 8'd0;
    logic       e_zero  = 1'b0;
    logic       e_carry = 1'b0;
    logic       e_wr    = 1'b0;

    always #2 clk = ~clk;

    alu_core i_alu_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (res_o),
        .zero_o  (zero_o),
        .carry_o (carry_o),
        .wr_o    (wr_o)
    );

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R4";
            4'd7, 4'd8: return "R5";
            4'd9: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Bench model: updates the expected state from the requirements.
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] t;
        int s;
        s = int'(b[2:0]);
        e_wr = 1'b0;
        case (op)
            4'd0: begin t = {1'b0, a} + {1'b0, b}; e_res = t[7:0]; e_carry = t[8]; e_wr = 1'b1; end
            4'd1: begin e_res = a - b; e_carry = (a >= b); e_wr = 1'b1; end
            4'd2: begin e_res = a & b; e_carry = 1'b0; e_wr = 1'b1; end
            4'd3: begin e_res = a | b; e_carry = 1'b0; e_wr = 1'b1; end
            4'd4: begin e_res = a ^ b; e_carry = 1'b0; e_wr = 1'b1; end
            4'd5: begin e_res = a << s; e_carry = 1'b0; e_wr = 1'b1; end
            4'd6: begin e_res = a >> s; e_carry = 1'b0; e_wr = 1'b1; end
            4'd7: begin e_res = 8'((a << s) | (a >> (8 - s))); e_carry = 1'b0; e_wr = 1'b1; end
            4'd8: begin e_res = 8'((a >> s) | (a << (8 - s))); e_carry = 1'b0; e_wr = 1'b1; end
            4'd9: begin e_res = a & b; end
            default: ;
        endcase
        if (op <= 4'd9) e_zero = (e_res == 8'd0);
    endtask

    task automatic run(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        string tg;
        tg = op_tag(op);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        model(op, a, b);
        @(negedge clk);
        check(tg, "res", int'(res_o), int'(e_res));
        check(tg, "carry", int'(carry_o), int'(e_carry));
        check((op <= 4'd8) ? "R7" : tg, "zero", int'(zero_o), int'(e_zero));
        check((op == 4'd9) ? "R8" : "R9", "wr", int'(wr_o), int'(e_wr));
    endtask

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd20240611));
        #3;
        // R10: reset state
        check("R10", "reset res", int'(res_o), 0);
        check("R10", "reset flags", int'({zero_o, carry_o, wr_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 and R7 in one cycle: wrap to zero with carry out.
        run(4'd0, 8'h80, 8'h80);
        run(4'd0, 8'h01, 8'hFF);
        run(4'd0, 8'h12, 8'h34);
        // R2: equal operands give zero and no borrow; borrow case.
        run(4'd1, 8'h55, 8'h55);
        run(4'd1, 8'h10, 8'h20);
        // R2: subtracting n equals adding 256-n.
        run(4'd1, 8'h9C, 8'h07);
        keep = res_o;
        run(4'd0, 8'h9C, 8'(9'd256 - 9'd7));
        check("R2", "sub vs add-complement", int'(res_o), int'(keep));
        // R8: test after a carry-setting add keeps carry.
        run(4'd0, 8'hF0, 8'h20);
        run(4'd9, 8'h80, 8'h7F);
        run(4'd9, 8'h80, 8'h80);
        // R3
        run(4'd2, 8'hF0, 8'h0F);
        run(4'd3, 8'hA0, 8'h05);
        run(4'd4, 8'hFF, 8'hFF);
        // R4: upper amount bits ignored
        run(4'd5, 8'hFF, 8'hF3);
        keep = res_o;
        run(4'd5, 8'hFF, 8'h03);
        check("R4", "upper amount bits ignored", int'(res_o), int'(keep));
        run(4'd6, 8'h81, 8'h07);
        // R5
        run(4'd7, 8'h81, 8'h01);
        run(4'd8, 8'h81, 8'h04);
        // R6: zero amount for all four
        for (int op = 5; op <= 8; op++) begin
            run(4'(op), 8'hA7, 8'hF8);
            check("R6", "pass-through", int'(res_o), 32'hA7);
        end
        // R9: unused codes keep state
        run(4'd0, 8'hFF, 8'h02);
        run(4'd12, 8'h00, 8'h00);
        run(4'd15, 8'h33, 8'h44);
        // R10: output waits for the sampling edge
        @(negedge clk);
        op_i = 4'd4; a_i = 8'h3C; b_i = 8'h0F;
        #1;
        check("R10", "no early change", int'(res_o), int'(e_res));
        model(4'd4, 8'h3C, 8'h0F);
        @(negedge clk);
        check("R10", "after edge", int'(res_o), 32'h33);

        // Random mix, biased toward zero-and-carry coincidences.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [7:0] a, b;
            op = 4'($urandom % 16);
            a  = 8'($urandom);
            b  = 8'($urandom);
            if ((i % 7) == 0) b = 8'(9'd256 - {1'b0, a});
            if ((i % 11) == 0) b = a;
            run(op, a, b);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule